// File: doc/BRIEF.md
# Vertical Sync Qualifier and Field Countdown

This block produces the vertical timing of a raster display from two strobes: one pulse per horizontal line and a fine timebase tick. It measures each low run of the incoming composite sync in ticks. A run that lasts at least a programmable minimum width counts as a vertical sync. The minimum is either the wide or the narrow setting. In single-run mode one such run is enough. In paired mode a second qualifying run must follow on the next line. After each accepted detection, further runs are ignored for a few lines, so the broad pulses of one vertical interval yield one detection.

A lock tracker measures the number of lines between successive detections. It calls a detection in-window when that count lies inside the pull-in range. The range is 235 to 286 lines, which is about 55 to 67 Hz at 15.734 kHz. Three in-window detections in a row declare lock. Three misses in a row drop it. A miss is an out-of-window detection or a silence longer than the range. While locked, each in-window detection restarts the line countdown. While unlocked, or when free-run is forced, the countdown wraps every 262 lines, which is about 60 Hz.

The countdown drives two registered outputs. The blanking window opens at the start of each field. The vertical pulse starts a selectable number of two-line steps later. A stop control holds the pulse low, and a separate control suppresses blanking. A status flag reads 1 while no vertical sync is locked.

Top module: `vsync_timer`

## Requirements
- R1: While `rst` is high, `vpulse_o` and `vblank_o` are 0 and `vlost_o` is 1.
- R2: With no accepted sync, the rising edges of `vpulse_o` are FREE_LINES line strobes apart (262 by default).
- R3: `vblank_o` is high for BLANK_LINES line strobes, starting at field start. `vpulse_o` is high for PULSE_LINES line strobes, starting 2 × `vshift_i` lines after the rise of `vblank_o`.
- R4: A sync low run qualifies when it lasts at least WIDE_TICKS ticks (18) with `narrow_i` = 0, or NARROW_TICKS ticks (14) with `narrow_i` = 1. Shorter runs are ignored.
- R5: With `one_win_i` = 0, a detection needs qualifying runs on two successive lines. A lone run per field is never detected. With `one_win_i` = 1, one run suffices.
- R6: A detection is in-window only when LOCK_MIN to LOCK_MAX line strobes have passed since the previous detection (235 to 286). Any other detection is a miss. Reaching LOCK_MAX lines without a detection is also a miss.
- R7: `vlost_o` falls after three consecutive in-window detections. It rises after three consecutive misses and not earlier.
- R8: While locked, each in-window detection restarts the field, so the pulse period equals the sync period. With sync absent and lock held, the field wraps after LOCK_MAX+1 lines.
- R9: With `force_free_i` = 1, the field period is FREE_LINES whatever the sync, and `vlost_o` still follows the lock tracker.
- R10: `vstop_i` = 1 holds `vpulse_o` low. `blank_off_i` = 1 holds `vblank_o` low.
- R11: After a detection, qualifying runs are ignored for HOLD_LINES line strobes. Broad pulses on two successive lines in single-run mode therefore give one detection per field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Fine timebase strobe for width measurement |
| line_stb_i | input | 1 | One-cycle strobe per horizontal line |
| csync_n_i | input | 1 | Composite sync, low during sync |
| narrow_i | input | 1 | 1 selects the narrow minimum width |
| one_win_i | input | 1 | 1 accepts a single qualifying run |
| force_free_i | input | 1 | 1 forces free-running field timing |
| vshift_i | input | SHIFT_BITS | Pulse start offset in two-line steps |
| vstop_i | input | 1 | 1 holds the vertical pulse low |
| blank_off_i | input | 1 | 1 suppresses vertical blanking |
| vpulse_o | output | 1 | Vertical pulse |
| vblank_o | output | 1 | Vertical blanking window |
| vlost_o | output | 1 | 1 while vertical sync is not locked |

## Verification
Two of the block's functions can fall in the same cycle: a field end from the countdown's own wrap, and a sync-driven restart or lock decision. In the loss test this happens because the lock timeout and the long-field wrap both occur at line LOCK_MAX. That test removes sync while locked and checks three things: the period stays LOCK_MAX+1, `vlost_o` is still low after two fields, and `vlost_o` is high after the third miss. Forcing free-run while sync stays locked provokes the other collision, a detection on a cycle where the countdown must ignore it. That case is judged by a period of FREE_LINES together with a `vlost_o` that stays low.

// File: rtl/vsync_timer_pkg.sv
package vsync_timer_pkg;

  typedef enum logic {
    PAIR_IDLE  = 1'b0,
    PAIR_ARMED = 1'b1
  } pair_state_t;

endpackage

// File: rtl/vsync_timer_qual.sv
module vsync_timer_qual
  import vsync_timer_pkg::*;
#(
  parameter int WIDE_TICKS   = 18,
  parameter int NARROW_TICKS = 14,
  parameter int HOLD_LINES   = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_i,
  input  logic line_stb_i,
  input  logic csync_n_i,
  input  logic narrow_i,
  input  logic one_win_i,
  output logic vdet_o
);

  localparam int MAXT = (WIDE_TICKS > NARROW_TICKS) ? WIDE_TICKS : NARROW_TICKS;
  localparam int TW   = $clog2(MAXT + 2);
  localparam int HW   = $clog2(HOLD_LINES + 2);

  logic [TW-1:0] run_q;
  logic          fired_q;
  logic [TW-1:0] thr;
  logic          hit;
  logic          hold_busy;
  logic          vdet_n;
  pair_state_t   pair_q;
  logic          age_q;
  logic [HW-1:0] hold_q;

  assign thr       = narrow_i ? TW'(NARROW_TICKS) : TW'(WIDE_TICKS);
  assign hit       = !csync_n_i && tick_i && !fired_q && ((run_q + TW'(1)) == thr);
  assign hold_busy = (hold_q != '0);

  // low-run width measurement
  always_ff @(posedge clk) begin
    if (rst) begin
      run_q   <= '0;
      fired_q <= 1'b0;
    end else if (csync_n_i) begin
      run_q   <= '0;
      fired_q <= 1'b0;
    end else if (tick_i && !fired_q) begin
      run_q <= run_q + TW'(1);
      if (hit) fired_q <= 1'b1;
    end
  end

  always_comb begin
    vdet_n = 1'b0;
    if (hit && !hold_busy && (one_win_i || pair_q == PAIR_ARMED)) vdet_n = 1'b1;
  end

  // pairing window and post-detection holdoff
  always_ff @(posedge clk) begin
    if (rst) begin
      pair_q <= PAIR_IDLE;
      age_q  <= 1'b0;
      hold_q <= '0;
      vdet_o <= 1'b0;
    end else begin
      vdet_o <= vdet_n;
      if (vdet_n) begin
        hold_q <= HW'(HOLD_LINES);
        pair_q <= PAIR_IDLE;
        age_q  <= 1'b0;
      end else begin
        if (line_stb_i && hold_busy) hold_q <= hold_q - HW'(1);
        if (hit && !hold_busy) begin
          pair_q <= PAIR_ARMED;
          age_q  <= 1'b0;
        end else if (line_stb_i && pair_q == PAIR_ARMED) begin
          if (age_q) pair_q <= PAIR_IDLE;
          else       age_q  <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/vsync_timer_lock.sv
module vsync_timer_lock #(
  parameter int LOCK_MIN   = 235,
  parameter int LOCK_MAX   = 286,
  parameter int LOCK_COUNT = 3,
  parameter int LW         = 9
) (
  input  logic clk,
  input  logic rst,
  input  logic line_stb_i,
  input  logic vdet_i,
  output logic locked_o,
  output logic accept_o
);

  localparam int CW = $clog2(LOCK_COUNT + 1);

  logic [LW-1:0] span_q;
  logic [CW-1:0] hits_q;
  logic [CW-1:0] miss_q;
  logic          in_win;
  logic          timeout;
  logic          good;
  logic          bad;

  assign in_win   = (span_q >= LW'(LOCK_MIN)) && (span_q <= LW'(LOCK_MAX));
  assign timeout  = line_stb_i && (span_q == LW'(LOCK_MAX)) && !vdet_i;
  assign good     = vdet_i && in_win;
  assign bad      = (vdet_i && !in_win) || timeout;
  assign accept_o = good && locked_o;

  always_ff @(posedge clk) begin
    if (rst) begin
      span_q   <= '0;
      hits_q   <= '0;
      miss_q   <= '0;
      locked_o <= 1'b0;
    end else begin
      if (vdet_i || timeout) span_q <= '0;
      else if (line_stb_i)   span_q <= span_q + LW'(1);

      if (good) begin
        miss_q <= '0;
        if (hits_q != CW'(LOCK_COUNT)) hits_q <= hits_q + CW'(1);
        if (hits_q >= CW'(LOCK_COUNT - 1)) locked_o <= 1'b1;
      end else if (bad) begin
        hits_q <= '0;
        if (miss_q != CW'(LOCK_COUNT)) miss_q <= miss_q + CW'(1);
        if (miss_q >= CW'(LOCK_COUNT - 1)) locked_o <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/vsync_timer_count.sv
module vsync_timer_count #(
  parameter int FREE_LINES  = 262,
  parameter int LOCK_MAX    = 286,
  parameter int PULSE_LINES = 8,
  parameter int BLANK_LINES = 24,
  parameter int SHIFT_STEP  = 2,
  parameter int SHIFT_BITS  = 3,
  parameter int LW          = 9
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  line_stb_i,
  input  logic                  restart_i,
  input  logic                  long_i,
  input  logic [SHIFT_BITS-1:0] vshift_i,
  input  logic                  vstop_i,
  input  logic                  blank_off_i,
  output logic [LW-1:0]         lc_o,
  output logic                  vpulse_o,
  output logic                  vblank_o
);

  logic [LW-1:0] limit;
  logic [LW-1:0] start;
  logic [LW-1:0] stop;

  assign limit = long_i ? LW'(LOCK_MAX) : LW'(FREE_LINES - 1);
  assign start = LW'(vshift_i) * LW'(SHIFT_STEP);
  assign stop  = start + LW'(PULSE_LINES);

  always_ff @(posedge clk) begin
    if (rst) begin
      lc_o <= '0;
    end else if (restart_i) begin
      lc_o <= '0;
    end else if (line_stb_i) begin
      lc_o <= (lc_o >= limit) ? '0 : lc_o + LW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vpulse_o <= 1'b0;
      vblank_o <= 1'b0;
    end else begin
      vpulse_o <= !vstop_i && (lc_o >= start) && (lc_o < stop);
      vblank_o <= !blank_off_i && (lc_o < LW'(BLANK_LINES));
    end
  end

endmodule

// File: rtl/vsync_timer.sv
module vsync_timer #(
  parameter int WIDE_TICKS   = 18,
  parameter int NARROW_TICKS = 14,
  parameter int HOLD_LINES   = 8,
  parameter int FREE_LINES   = 262,
  parameter int LOCK_MIN     = 235,
  parameter int LOCK_MAX     = 286,
  parameter int LOCK_COUNT   = 3,
  parameter int PULSE_LINES  = 8,
  parameter int BLANK_LINES  = 24,
  parameter int SHIFT_STEP   = 2,
  parameter int SHIFT_BITS   = 3
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  tick_i,
  input  logic                  line_stb_i,
  input  logic                  csync_n_i,
  input  logic                  narrow_i,
  input  logic                  one_win_i,
  input  logic                  force_free_i,
  input  logic [SHIFT_BITS-1:0] vshift_i,
  input  logic                  vstop_i,
  input  logic                  blank_off_i,
  output logic                  vpulse_o,
  output logic                  vblank_o,
  output logic                  vlost_o
);

  localparam int LW = $clog2(LOCK_MAX + 2);

  logic          vdet;
  logic          locked;
  logic          accept;
  logic          restart;
  logic          long_field;
  logic [LW-1:0] lc;

  vsync_timer_qual #(
    .WIDE_TICKS  (WIDE_TICKS),
    .NARROW_TICKS(NARROW_TICKS),
    .HOLD_LINES  (HOLD_LINES)
  ) u_qual (
    .clk       (clk),
    .rst       (rst),
    .tick_i    (tick_i),
    .line_stb_i(line_stb_i),
    .csync_n_i (csync_n_i),
    .narrow_i  (narrow_i),
    .one_win_i (one_win_i),
    .vdet_o    (vdet)
  );

  vsync_timer_lock #(
    .LOCK_MIN  (LOCK_MIN),
    .LOCK_MAX  (LOCK_MAX),
    .LOCK_COUNT(LOCK_COUNT),
    .LW        (LW)
  ) u_lock (
    .clk       (clk),
    .rst       (rst),
    .line_stb_i(line_stb_i),
    .vdet_i    (vdet),
    .locked_o  (locked),
    .accept_o  (accept)
  );

  assign restart    = accept && !force_free_i;
  assign long_field = locked && !force_free_i;

  vsync_timer_count #(
    .FREE_LINES (FREE_LINES),
    .LOCK_MAX   (LOCK_MAX),
    .PULSE_LINES(PULSE_LINES),
    .BLANK_LINES(BLANK_LINES),
    .SHIFT_STEP (SHIFT_STEP),
    .SHIFT_BITS (SHIFT_BITS),
    .LW         (LW)
  ) u_count (
    .clk        (clk),
    .rst        (rst),
    .line_stb_i (line_stb_i),
    .restart_i  (restart),
    .long_i     (long_field),
    .vshift_i   (vshift_i),
    .vstop_i    (vstop_i),
    .blank_off_i(blank_off_i),
    .lc_o       (lc),
    .vpulse_o   (vpulse_o),
    .vblank_o   (vblank_o)
  );

  always_ff @(posedge clk) begin
    if (rst) vlost_o <= 1'b1;
    else     vlost_o <= !locked;
  end

endmodule

// File: rtl/vsync_timer_chk.sv
module vsync_timer_chk #(
  parameter int LOCK_MAX = 286,
  parameter int LW       = 9
) (
  input logic          clk,
  input logic          rst,
  input logic          line_stb_i,
  input logic          csync_n_i,
  input logic          force_free_i,
  input logic          vstop_i,
  input logic          blank_off_i,
  input logic          vdet,
  input logic          locked,
  input logic          restart,
  input logic [LW-1:0] lc,
  input logic          vpulse_o,
  input logic          vblank_o
);

  a_r10_stop_holds_pulse: assert property (@(posedge clk) disable iff (rst)
    vstop_i |=> !vpulse_o);

  a_r10_blank_suppressed: assert property (@(posedge clk) disable iff (rst)
    blank_off_i |=> !vblank_o);

  a_r4_detect_from_low_run: assert property (@(posedge clk) disable iff (rst)
    vdet |-> $past(!csync_n_i));

  a_r8_restart_clears_count: assert property (@(posedge clk) disable iff (rst)
    restart |=> (lc == '0));

  a_r9_forced_no_jump: assert property (@(posedge clk) disable iff (rst)
    (force_free_i && !line_stb_i) |=> $stable(lc));

  a_r7_lock_follows_detect: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> $past(vdet));

  a_r2_count_in_range: assert property (@(posedge clk) disable iff (rst)
    lc <= LW'(LOCK_MAX));

endmodule

bind vsync_timer vsync_timer_chk #(
  .LOCK_MAX(LOCK_MAX),
  .LW      (LW)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .line_stb_i  (line_stb_i),
  .csync_n_i   (csync_n_i),
  .force_free_i(force_free_i),
  .vstop_i     (vstop_i),
  .blank_off_i (blank_off_i),
  .vdet        (vdet),
  .locked      (locked),
  .restart     (restart),
  .lc          (lc),
  .vpulse_o    (vpulse_o),
  .vblank_o    (vblank_o)
);

// File: tb/test_vsync_timer.sv
`timescale 1ns/1ps
module test_vsync_timer;

  localparam int FREE   = 40;
  localparam int LMIN   = 35;
  localparam int LMAX   = 45;
  localparam int PULSE  = 3;
  localparam int BLANK  = 8;
  localparam int LINE_CLK = 24;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b1;
  logic line_stb = 1'b0;
  logic csync_n = 1'b1;
  logic narrow = 1'b0;
  logic one_win = 1'b1;
  logic force_free = 1'b0;
  logic [2:0] vshift = 3'd0;
  logic vstop = 1'b0;
  logic blank_off = 1'b0;
  logic vpulse, vblank, vlost;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  int sync_period = 0;
  int sync_width = 18;
  bit sync_dbl = 0;
  int line_idx = 0;

  int p_rise = 0, p_period = -1, p_width = -1;
  int b_rise = 0, b_width = -1, offset = -1;
  int pulse_cnt = 0, blank_cnt = 0;
  logic pv = 1'b0, bv = 1'b0;

  always #5 clk = ~clk;

  vsync_timer #(
    .FREE_LINES(FREE), .LOCK_MIN(LMIN), .LOCK_MAX(LMAX),
    .PULSE_LINES(PULSE), .BLANK_LINES(BLANK), .HOLD_LINES(4)
  ) i_vsync_timer (
    .clk(clk), .rst(rst), .tick_i(tick), .line_stb_i(line_stb),
    .csync_n_i(csync_n), .narrow_i(narrow), .one_win_i(one_win),
    .force_free_i(force_free), .vshift_i(vshift), .vstop_i(vstop),
    .blank_off_i(blank_off), .vpulse_o(vpulse), .vblank_o(vblank),
    .vlost_o(vlost)
  );

  // line and sync driver
  initial begin
    int ph;
    bit low;
    ph = 0;
    wait (!rst);
    forever begin
      @(negedge clk);
      line_stb = 1'b1;
      line_idx++;
      low = (sync_period != 0) && (ph == 0 || (sync_dbl && ph == 1));
      ph = (sync_period != 0 && ph + 1 < sync_period) ? ph + 1 : 0;
      for (int c = 0; c < LINE_CLK; c++) begin
        if (c > 0) begin
          @(negedge clk);
          line_stb = 1'b0;
        end
        csync_n = !(low && c < sync_width);
      end
    end
  end

  // output monitor, sampled after the edge
  always @(posedge clk) begin
    #2;
    if (!rst) begin
      if (vblank && !bv) begin b_rise = line_idx; blank_cnt++; end
      if (!vblank && bv) b_width = line_idx - b_rise;
      if (vpulse && !pv) begin
        p_period = line_idx - p_rise;
        p_rise = line_idx;
        offset = line_idx - b_rise;
        pulse_cnt++;
      end
      if (!vpulse && pv) p_width = line_idx - p_rise;
      pv = vpulse;
      bv = vblank;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_pulses(input int n);
    int tgt;
    tgt = pulse_cnt + n;
    while (pulse_cnt < tgt) @(negedge clk);
  endtask

  task automatic wait_lines(input int n);
    int tgt;
    tgt = line_idx + n;
    while (line_idx < tgt) @(negedge clk);
  endtask

  task automatic drop_sync;
    sync_period = 0;
    wait_pulses(6);
    check(vlost == 1'b1, "R7 unlocked after sync removed", vlost, 1);
  endtask

  task automatic t_reset;
    repeat (4) @(negedge clk);
    check(vpulse == 1'b0, "R1 vpulse in reset", vpulse, 0);
    check(vblank == 1'b0, "R1 vblank in reset", vblank, 0);
    check(vlost == 1'b1, "R1 vlost in reset", vlost, 1);
    rst = 1'b0;
  endtask

  task automatic t_free_run;
    wait_pulses(3);
    check(p_period == FREE, "R2 free-run period", p_period, FREE);
    check(p_width == PULSE, "R3 pulse width", p_width, PULSE);
    check(b_width == BLANK, "R3 blank width", b_width, BLANK);
    check(offset == 0, "R3 offset shift 0", offset, 0);
    check(vlost == 1'b1, "R7 no sync unlocked", vlost, 1);
  endtask

  task automatic t_shift;
    vshift = 3'd5;
    wait_pulses(3);
    check(offset == 10, "R3 offset shift 5", offset, 10);
    check(p_width == PULSE, "R3 shifted pulse width", p_width, PULSE);
    vshift = 3'd0;
    wait_pulses(1);
  endtask

  task automatic t_lock;
    sync_period = 38; sync_width = 18; sync_dbl = 0; one_win = 1; narrow = 0;
    wait_pulses(7);
    check(vlost == 1'b0, "R7 locked to in-window sync", vlost, 0);
    wait_pulses(2);
    check(p_period == 38, "R8 period follows sync", p_period, 38);
  endtask

  task automatic t_force;
    force_free = 1'b1;
    wait_pulses(3);
    check(p_period == FREE, "R9 forced period", p_period, FREE);
    check(vlost == 1'b0, "R9 lock still tracked", vlost, 0);
    force_free = 1'b0;
    wait_pulses(3);
    check(p_period == 38, "R9 released back to sync", p_period, 38);
  endtask

  task automatic t_loss;
    sync_period = 0;
    wait_pulses(2);
    check(p_period == LMAX + 1, "R8 flywheel period", p_period, LMAX + 1);
    check(vlost == 1'b0, "R7 held after two misses", vlost, 0);
    wait_pulses(4);
    check(vlost == 1'b1, "R7 dropped after three misses", vlost, 1);
    wait_pulses(2);
    check(p_period == FREE, "R2 free-run after loss", p_period, FREE);
  endtask

  task automatic t_holdoff;
    sync_period = 38; sync_dbl = 1; one_win = 1;
    wait_pulses(8);
    check(vlost == 1'b0, "R11 double runs lock in single mode", vlost, 0);
    check(p_period == 38, "R11 one detection per field", p_period, 38);
    drop_sync();
  endtask

  task automatic t_pair;
    one_win = 0; sync_dbl = 0; sync_period = 38;
    wait_pulses(8);
    check(vlost == 1'b1, "R5 lone run rejected in paired mode", vlost, 1);
    sync_dbl = 1;
    wait_pulses(8);
    check(vlost == 1'b0, "R5 paired runs lock", vlost, 0);
    check(p_period == 38, "R5 paired period", p_period, 38);
    drop_sync();
    one_win = 1; sync_dbl = 0;
  endtask

  task automatic t_width;
    narrow = 0; sync_width = 17; sync_period = 38;
    wait_pulses(8);
    check(vlost == 1'b1, "R4 17 ticks below wide minimum", vlost, 1);
    narrow = 1;
    wait_pulses(8);
    check(vlost == 1'b0, "R4 17 ticks pass narrow minimum", vlost, 0);
    check(p_period == 38, "R4 narrow lock period", p_period, 38);
    drop_sync();
    narrow = 0; sync_width = 18;
  endtask

  task automatic t_range;
    sync_period = 50;
    wait_pulses(8);
    check(vlost == 1'b1, "R6 too long period rejected", vlost, 1);
    check(p_period == FREE, "R6 free-run with long sync", p_period, FREE);
    sync_period = 30;
    wait_pulses(8);
    check(vlost == 1'b1, "R6 too short period rejected", vlost, 1);
    sync_period = 0;
  endtask

  task automatic t_stop;
    int pc, bc;
    vstop = 1'b1; blank_off = 1'b1;
    wait_lines(2);
    pc = pulse_cnt; bc = blank_cnt;
    wait_lines(2 * FREE + 5);
    check(pulse_cnt == pc, "R10 no pulse while stopped", pulse_cnt - pc, 0);
    check(blank_cnt == bc, "R10 no blank while disabled", blank_cnt - bc, 0);
    vstop = 1'b0; blank_off = 1'b0;
    wait_lines(2 * FREE + 5);
    check(pulse_cnt > pc, "R10 pulse resumes", pulse_cnt - pc, 2);
  endtask

  initial begin
    t_reset();
    t_free_run();
    t_shift();
    t_lock();
    t_force();
    t_loss();
    t_holdoff();
    t_pair();
    t_width();
    t_range();
    t_stop();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule